// File: doc/BRIEF.md
# Asynchronous SRAM port controller

This block sits between a single-clock host and an external asynchronous static RAM of 8192 words of 9 bits, whose data pins carry both read and write data. The host gives one request at a time through a valid/ready handshake: a write flag, a 13-bit word address and 9 bits of write data. The controller then runs a whole memory cycle on the RAM pins. It drives the address, a low-active select and a high-active select (the RAM is chosen only when both are active), a low-active output enable and a low-active write strobe, and it controls the driver of the shared data bus. When the cycle is complete it reports with a one-cycle response pulse, which carries the read data for a read.

Each phase of a cycle lasts a fixed number of clock cycles, set by parameters: the access window, the bus turnaround wait and the write strobe width. Each parameter is the nanosecond figure of the speed grade divided by the clock period and rounded up. For example, a 25 ns grade at a 4 ns clock gives an access window of 7, a turnaround of 3 and a strobe width of 3.

Back-pressure rules: `req_ready` is high only while the controller is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold its request fields stable until that edge. The response has no ready signal. `rsp_valid` is a single-cycle pulse that the host must take when it occurs, and `rsp_rdata` then holds its value until the next read completes.

Top module: `sram_port_ctl`

## Requirements
- R1: While reset is high and afterwards until the first request, mem_ce_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0, busy=0, req_ready=1 and rsp_valid=0.
- R2: A request is taken only on an edge where req_valid=1 and req_ready=1. req_ready is 0 and busy is 1 from the cycle after acceptance through the response cycle, and a request held valid during that time is taken on the first idle cycle after the response. For a write, that is cycle T_TURN+T_WP+3 after the first acceptance.
- R3: A read holds mem_addr=address, mem_ce_n=0, mem_ce2=1, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for exactly T_ACC cycles after acceptance.
- R4: Read data is sampled from mem_dq_in at the edge that ends the last access cycle. It appears on rsp_rdata with rsp_valid=1 in cycle T_ACC+1 after acceptance, and it stays unchanged through later writes.
- R5: A write first holds the RAM selected, with mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0, for T_TURN cycles.
- R6: The write then holds mem_we_n=0 for exactly T_WP cycles, with mem_dq_oe=1, mem_dq_out=write data and the RAM selected.
- R7: In the cycle after mem_we_n returns to 1, the RAM stays selected and mem_dq_oe, mem_addr and mem_dq_out are unchanged. rsp_valid=1 follows in cycle T_TURN+T_WP+2 after acceptance.
- R8: mem_dq_oe is never 1 while the RAM is selected with mem_oe_n=0. It rises only after at least T_TURN cycles in which the RAM was not driving.
- R9: In the idle cycle and in the response cycle both selects are inactive (mem_ce_n=1, mem_ce2=0), and mem_dq_oe=0.
- R10: rsp_valid is high for exactly one cycle, once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 9 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 9 | Data from the last completed read |
| busy | output | 1 | A memory cycle is in progress |
| mem_addr | output | 13 | RAM address bus |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_ce2 | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 9 | Value put on the shared data bus |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | 9 | Value read from the shared data bus |

## Verification
Two things are hard to reach from the ports. The first is a read whose data is taken one cycle early. The bench's RAM model returns a junk value until the address and enables have been stable for T_ACC-1 edges, so an early sample shows up as wrong read data. The second is a write driver that turns on too soon after a read, and a request that is still held valid when a cycle finishes. Reads and writes are interleaved on the same and on neighbouring addresses, while a monitor counts the cycles in which the bus floated before each driver turn-on. One request is also kept valid across another so that its acceptance cycle can be measured.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_DONE
  } ctl_state_t;
endpackage

// File: rtl/sram_timer.sv
// Phase length counter: loaded with length-1, reports zero on the last cycle.
module sram_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_seq.sv
// Cycle sequencer: read window, write setup / strobe / hold, response.
module sram_seq
  import sram_ctl_pkg::*;
#(
  parameter int T_ACC  = 7,
  parameter int T_TURN = 3,
  parameter int T_WP   = 3,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output ctl_state_t       state_q,
  output ctl_state_t       state_d,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);
  localparam logic [CNT_W-1:0] LD_ACC  = CNT_W'(T_ACC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(T_TURN - 1);
  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(T_WP - 1);

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WSET;
            tmr_val = LD_TURN;
          end else begin
            state_d = ST_RD;
            tmr_val = LD_ACC;
          end
        end
      end
      ST_RD: begin
        if (tmr_zero) begin
          capture = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_WSET: begin
        if (tmr_zero) begin
          state_d  = ST_WPUL;
          tmr_load = 1'b1;
          tmr_val  = LD_WP;
        end
      end
      ST_WPUL: begin
        if (tmr_zero) state_d = ST_WHLD;
      end
      ST_WHLD: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/sram_dpath.sv
// Request latches, read capture and registered pin drive decoded from the next state.
module sram_dpath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_state_t        state_d,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              req_ready,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  logic nx_sel, nx_drive;

  assign nx_sel   = (state_d == ST_RD) || (state_d == ST_WSET) ||
                    (state_d == ST_WPUL) || (state_d == ST_WHLD);
  assign nx_drive = (state_d == ST_WPUL) || (state_d == ST_WHLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n  <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      req_ready <= 1'b1;
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      mem_ce_n  <= !nx_sel;
      mem_ce2   <= nx_sel;
      mem_oe_n  <= (state_d != ST_RD);
      mem_we_n  <= (state_d != ST_WPUL);
      mem_dq_oe <= nx_drive;
      req_ready <= (state_d == ST_IDLE);
      busy      <= (state_d != ST_IDLE);
      rsp_valid <= (state_d == ST_DONE);
    end
  end
endmodule

// File: rtl/sram_port_ctl.sv
module sram_port_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 9,
  parameter int T_ACC  = 7,
  parameter int T_TURN = 3,
  parameter int T_WP   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int T_MAX = (T_ACC > T_TURN) ? ((T_ACC > T_WP) ? T_ACC : T_WP)
                                          : ((T_TURN > T_WP) ? T_TURN : T_WP);
  localparam int CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  ctl_state_t       state_q, state_d;
  logic             accept, capture, tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  sram_seq #(
    .T_ACC(T_ACC), .T_TURN(T_TURN), .T_WP(T_WP), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .tmr_zero(tmr_zero),
    .state_q(state_q), .state_d(state_d),
    .accept(accept), .capture(capture),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sram_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst),
    .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst),
    .state_d(state_d), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .req_ready(req_ready), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );
endmodule

// File: rtl/sram_port_ctl_chk.sv
module sram_port_ctl_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 9,
  parameter int T_TURN = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              busy,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  logic       ram_sel;
  logic [7:0] float_cnt;

  assign ram_sel = !mem_ce_n && mem_ce2;

  always_ff @(posedge clk) begin
    if (rst)                       float_cnt <= 8'hFF;
    else if (ram_sel && !mem_oe_n) float_cnt <= 8'h00;
    else if (float_cnt != 8'hFF)   float_cnt <= float_cnt + 8'h01;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !(ram_sel && !mem_oe_n)); // R8
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (float_cnt >= 8'(T_TURN))); // R8
  AST_RD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && ram_sel)); // R3
  AST_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_dq_oe && ram_sel)); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && ram_sel && $stable(mem_addr) && $stable(mem_dq_out))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (rst)
    (req_ready || rsp_valid) |-> (mem_ce_n && !mem_ce2 && !mem_dq_oe)); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (busy && !req_ready)); // R2
endmodule

bind sram_port_ctl sram_port_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_TURN(T_TURN)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .busy(busy), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_port_ctl_tb.sv
`timescale 1ns/1ps
module sram_port_ctl_tb;
  localparam int AW = 13, DW = 9, T_ACC = 7, T_TURN = 3, T_WP = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, busy;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;

  always #2 clk = ~clk;

  sram_port_ctl #(.ADDR_W(AW), .DATA_W(DW), .T_ACC(T_ACC), .T_TURN(T_TURN), .T_WP(T_WP)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, fails = 0;
  bit done_rep = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done_rep) begin
      done_rep = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] pat(int a, int s);
    return DW'((a * 5 + s * 91 + (a >> 4)) & 'h1FF);
  endfunction

  // RAM model: data valid only after T_ACC-1 stable read edges
  logic [DW-1:0] ram [DEPTH];
  int acc_cnt = 0;
  wire ram_sel = !mem_ce_n && mem_ce2;
  always @(posedge clk) begin
    if (ram_sel && !mem_oe_n && mem_we_n) acc_cnt <= (acc_cnt < 60) ? acc_cnt + 1 : acc_cnt;
    else acc_cnt <= 0;
    if (ram_sel && !mem_we_n && mem_dq_oe) ram[mem_addr] <= mem_dq_out;
  end
  assign mem_dq_in = (acc_cnt >= T_ACC - 1) ? ram[mem_addr] : 9'h0AA;

  // bus monitor
  int float_cnt = 100, v_cont = 0, v_turn = 0, rsp_pulses = 0;
  bit oe_prev = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_dq_oe && ram_sel && !mem_oe_n) v_cont++;
      if (mem_dq_oe && !oe_prev && float_cnt < T_TURN) v_turn++;
      if (ram_sel && !mem_oe_n) float_cnt = 0;
      else if (float_cnt < 100) float_cnt++;
      oe_prev = mem_dq_oe;
      if (rsp_valid) rsp_pulses++;
    end
  end

  logic [DW-1:0] exp_mem [DEPTH];

  task automatic do_op(bit wr, int a, logic [DW-1:0] d, output logic [DW-1:0] rd);
    int lat, b3, b5, b6, b7, b2;
    @(negedge clk);
    chk(req_ready && !busy, "R2", "idle before request", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1; b2 = 0; b3 = 0; b5 = 0; b6 = 0; b7 = 0;
    while (!rsp_valid && lat < 100) begin
      if (!busy || req_ready) b2++;
      if (!wr) begin
        if (!(ram_sel && !mem_oe_n && mem_we_n && !mem_dq_oe && mem_addr == AW'(a))) b3++;
      end else if (lat <= T_TURN) begin
        if (!(ram_sel && mem_oe_n && mem_we_n && !mem_dq_oe && mem_addr == AW'(a))) b5++;
      end else if (lat <= T_TURN + T_WP) begin
        if (!(ram_sel && mem_oe_n && !mem_we_n && mem_dq_oe && mem_dq_out == d && mem_addr == AW'(a))) b6++;
      end else begin
        if (!(ram_sel && mem_oe_n && mem_we_n && mem_dq_oe && mem_dq_out == d && mem_addr == AW'(a))) b7++;
      end
      lat++;
      @(negedge clk);
    end
    chk(b2 == 0, "R2", "busy/ready during cycle", b2, 0);
    if (!wr) begin
      chk(b3 == 0, "R3", "read pin pattern", b3, 0);
      chk(lat == T_ACC + 1, "R4", "read response latency", lat, T_ACC + 1);
      chk(rsp_rdata == exp_mem[a], "R4", $sformatf("read data @%0h", a), rsp_rdata, exp_mem[a]);
    end else begin
      chk(b5 == 0, "R5", "write setup pins", b5, 0);
      chk(b6 == 0, "R6", "write strobe pins", b6, 0);
      chk(b7 == 0, "R7", "write hold pins", b7, 0);
      chk(lat == T_TURN + T_WP + 2, "R7", "write response latency", lat, T_TURN + T_WP + 2);
      exp_mem[a] = d;
    end
    rd = rsp_rdata;
    chk(mem_ce_n && !mem_ce2 && !mem_dq_oe && busy, "R9", "response cycle deselect",
        {mem_ce_n, mem_ce2, mem_dq_oe, busy}, 4'b1001);
    @(negedge clk);
    chk(!rsp_valid && !busy && req_ready, "R10", "single response pulse", rsp_valid, 0);
    chk(mem_ce_n && !mem_ce2 && !mem_dq_oe, "R9", "idle deselect", {mem_ce_n, mem_ce2}, 2'b10);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    chk(0, "R2", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic [DW-1:0] rd, last_rd;
    int n, p0;
    for (int i = 0; i < DEPTH; i++) begin ram[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk(mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !busy && req_ready && !rsp_valid,
        "R1", "pins in reset", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    rst = 0;
    repeat (2) @(negedge clk);
    chk(mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !busy && req_ready && !rsp_valid,
        "R1", "pins after reset", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);

    // full write sweep, then strided read-back
    for (int a = 0; a < DEPTH; a++) do_op(1, a, pat(a, 1), rd);
    for (int a = 0; a < DEPTH; a += 3) do_op(0, a, '0, rd);

    // read/write turnaround on corner addresses
    for (int k = 0; k < AW; k++) begin
      int a = 1 << k;
      do_op(0, a, '0, rd);
      do_op(1, a, pat(a, 2), rd);
      do_op(0, a, '0, rd);
      do_op(1, DEPTH - 1 - a, ~pat(a, 3), rd);
      do_op(0, DEPTH - 1 - a, '0, rd);
    end

    // read data held across a write (R4)
    do_op(0, 5, '0, last_rd);
    do_op(1, 6, 9'h1FF, rd);
    chk(rd == last_rd, "R4", "read data held over write", rd, last_rd);

    // request held valid across a busy cycle (R2, R10)
    p0 = rsp_pulses;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 13'h0123; req_wdata = 9'h0F0;
    @(posedge clk);
    @(negedge clk);
    req_addr = 13'h0124; req_wdata = 9'h10F;
    n = 1;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    chk(n == T_TURN + T_WP + 3, "R2", "held request acceptance cycle", n, T_TURN + T_WP + 3);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    exp_mem[13'h0123] = 9'h0F0; exp_mem[13'h0124] = 9'h10F;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(rsp_pulses - p0 == 2, "R10", "responses for two requests", rsp_pulses - p0, 2);
    do_op(0, 13'h0123, '0, rd);
    do_op(0, 13'h0124, '0, rd);

    chk(v_cont == 0, "R8", "bus contention cycles", v_cont, 0);
    chk(v_turn == 0, "R8", "early driver turn-on", v_turn, 0);
    report();
  end
endmodule